// File: doc/BRIEF.md
# Deadtime-Compensated Complementary PWM Pair

This block drives one half-bridge leg: a high-side output and a low-side output that are never on together. A free-running period counter is compared against a duty value, and that comparison is the raw high-side drive. Its inverse is the raw low-side drive. Each raw edge that switches an output on is delayed by a programmable number of clock cycles, so both switches stay off during every commutation.

Two duty inputs are offered, an even one and an odd one. A source-select input picks which of them governs the leg. The select input and the chosen duty are taken over only when a period ends, so a whole period always runs from one duty value. Firmware sets the select from the load-current direction, which lets it offset the voltage error that the deadtime introduces.

To tell firmware which way the current flows, a digital sense input is synchronised and then captured each time one of the outputs turns on after its deadtime. That gives two marker bits per period. Both low means current leaves the leg. Both high means current enters the leg. Unequal bits mean the current is near zero and the leg voltage was undefined during the deadtime.

Top module: `dtc_pwm_pair`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `pwm_top`=0, `pwm_bot`=0 and `dt_mark`=2'b00. The period count restarts at 0, and the active duty value and the latched source select both clear to 0.
- R2: The period count runs 0..PERIOD-1 and then wraps. If the latched source select is 0, `duty_even` sets the raw high-side drive; if it is 1, `duty_odd` does. The raw high-side drive is high while count < duty.
- R3: `src_sel` and the selected duty input are latched only on the clock edge where the count is PERIOD-1, with no enable condition. Changes made at any other time have no effect on the current period.
- R4: `pwm_top` is high in a cycle exactly when the raw high-side drive was high in each of the previous `dead_cycles`+1 cycles.
- R5: `pwm_bot` follows the same rule as R4, applied to the inverted raw drive.
- R6: `pwm_top` and `pwm_bot` are never high in the same cycle. When `dead_cycles` is nonzero, a falling `pwm_bot` is not met by a rising `pwm_top` in the same cycle.
- R7: A raw high run of L cycles with L <= `dead_cycles` gives no output pulse. A longer run gives a pulse of L-`dead_cycles` cycles.
- R8: A duty of 0 holds `pwm_top` low and `pwm_bot` on for the whole steady period. A duty >= PERIOD holds `pwm_top` on and `pwm_bot` low.
- R9: `isense` passes through a two-flop synchroniser. On the edge where `pwm_top` turns on, `dt_mark[0]` takes the synchronised value. On the edge where `pwm_bot` turns on, `dt_mark[1]` takes it.
- R10: Each `dt_mark` bit holds its value between its capture events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_even | input | DUTY_W | Even duty value |
| duty_odd | input | DUTY_W | Odd duty value |
| src_sel | input | 1 | Duty source select (0 even, 1 odd), latched at period end |
| dead_cycles | input | DT_W | Deadtime length in clock cycles |
| isense | input | 1 | Asynchronous digital current-direction sense |
| pwm_top | output | 1 | High-side gate drive |
| pwm_bot | output | 1 | Low-side gate drive |
| dt_mark | output | 2 | Captured sense bits: [0] at high-side turn-on, [1] at low-side turn-on |

## Verification
Several properties are checked on every cycle: the two outputs never overlap, the deadtime gap at a low-to-high handover, the active duty staying constant inside a period, the marker bits holding still between turn-on events, and the reset values. Other behaviour can only be shown by the bench's scenarios. That includes the exact pulse placement and width for each duty and deadtime pair, which source is used after a mid-period select change, suppression of short pulses, saturation at both duty extremes, and the captured sense value after synchroniser latency. The bench compares both outputs and both marker bits every cycle against an arithmetic model, across sweeps of duty pairs and deadtimes.

// File: rtl/dtc_pkg.sv
// Package: shared types and constants for the deadtime-compensated PWM pair.
// Assumes channel 0 is the high side and channel 1 the low side everywhere.
package dtc_pkg;

    // Duty source chosen by the latched select bit
    typedef enum logic {
        SRC_EVEN = 1'b0,
        SRC_ODD  = 1'b1
    } duty_src_e;

    localparam int NUM_CH = 2;
    localparam int CH_TOP = 0;
    localparam int CH_BOT = 1;

endpackage

// File: rtl/dtc_period_cnt.sv
// Module: free-running period counter.
// Counts 0..PERIOD-1 and flags the last count so neighbours can latch
// period-buffered values. Assumes PERIOD >= 2.
module dtc_period_cnt #(
    parameter int PERIOD = 16,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Flag the final count of the period
    assign last = (cnt_q == LAST_VAL);
    assign cnt  = cnt_q;

    // Advance the count, wrapping after the final value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dtc_duty_bank.sv
// Module: period-buffered duty source selection and edge compare.
// Latches the select bit and the duty it picks at every period end,
// unconditionally, then compares the running count against that duty to
// form the raw high-side drive. Assumes DUTY_W >= CNT_W.
module dtc_duty_bank
    import dtc_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_last,
    input  logic              src_sel,
    input  logic [DUTY_W-1:0] duty_even,
    input  logic [DUTY_W-1:0] duty_odd,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DUTY_W-1:0] duty_act,
    output logic              raw_top
);

    duty_src_e         src_q;
    duty_src_e         src_next;
    logic [DUTY_W-1:0] duty_next;
    logic [DUTY_W-1:0] duty_q;
    logic [DUTY_W-1:0] cnt_wide;

    // Decode the requested source and its duty value
    always_comb begin
        src_next  = src_sel ? SRC_ODD : SRC_EVEN;
        duty_next = (src_next == SRC_ODD) ? duty_odd : duty_even;
    end

    // Latch source and duty together once per period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_EVEN;
            duty_q <= '0;
        end else if (period_last) begin
            src_q  <= src_next;
            duty_q <= duty_next;
        end
    end

    // Compare the count against the active duty
    always_comb begin
        cnt_wide = DUTY_W'(cnt);
        raw_top  = (cnt_wide < duty_q);
    end

    assign duty_act = duty_q;

endmodule

// File: rtl/dtc_dead_gen.sv
// Module: turn-on delay for one output of the pair.
// The output goes low at once when its raw drive drops. It turns on only
// after the raw drive has been high for dead_cycles+1 consecutive edges.
// turn_on marks the edge where the output switches on.
module dtc_dead_gen #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_in,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            gate_out,
    output logic            turn_on
);

    logic [DT_W-1:0] wait_q;
    logic            gate_q;
    logic            ready;

    // The deadtime has elapsed while the raw drive stayed high
    assign ready    = raw_in && (wait_q >= dead_cycles);
    assign turn_on  = ready && !gate_q;
    assign gate_out = gate_q;

    // Count the deadtime and drive the gate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            gate_q <= 1'b0;
        end else if (!raw_in) begin
            wait_q <= '0;
            gate_q <= 1'b0;
        end else begin
            if (wait_q < dead_cycles) begin
                wait_q <= wait_q + DT_W'(1);
            end
            gate_q <= ready;
        end
    end

endmodule

// File: rtl/dtc_mark_cap.sv
// Module: current-direction marker capture.
// Synchronises the asynchronous sense input with two flops, then stores
// the synchronised value into one marker bit per channel on that
// channel's turn-on event. Each bit holds between events.
module dtc_mark_cap #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sense_in,
    input  logic [NCH-1:0] cap_evt,
    output logic [NCH-1:0] mark
);

    logic sync1_q;
    logic sync2_q;

    // Two-flop synchroniser on the sense input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= sense_in;
            sync2_q <= sync1_q;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_mark
        logic mark_q;

        // Capture the synchronised sense on this channel's turn-on
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mark_q <= 1'b0;
            end else if (cap_evt[ch]) begin
                mark_q <= sync2_q;
            end
        end

        assign mark[ch] = mark_q;
    end

endmodule

// File: rtl/dtc_pwm_pair.sv
// Module: complementary PWM pair with deadtime and deadtime-correction
// support. Assumes a single clock, a synchronous active-low reset,
// DUTY_W >= $clog2(PERIOD), and dead_cycles changed only while in reset.
module dtc_pwm_pair
    import dtc_pkg::*;
#(
    parameter int PERIOD = 16,
    parameter int DUTY_W = 8,
    parameter int DT_W   = 4,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_even,
    input  logic [DUTY_W-1:0] duty_odd,
    input  logic              src_sel,
    input  logic [DT_W-1:0]   dead_cycles,
    input  logic              isense,
    output logic              pwm_top,
    output logic              pwm_bot,
    output logic [1:0]        dt_mark
);

    logic [CNT_W-1:0]  cnt_q;
    logic              period_last;
    logic [DUTY_W-1:0] duty_act;
    logic              raw_top;
    logic [NUM_CH-1:0] raw_pair;
    logic [NUM_CH-1:0] gate;
    logic [NUM_CH-1:0] turn_on;

    // Period counter
    dtc_period_cnt #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_q),
        .last  (period_last)
    );

    // Buffered duty selection and compare
    dtc_duty_bank #(
        .CNT_W  (CNT_W),
        .DUTY_W (DUTY_W)
    ) u_duty (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_last (period_last),
        .src_sel     (src_sel),
        .duty_even   (duty_even),
        .duty_odd    (duty_odd),
        .cnt         (cnt_q),
        .duty_act    (duty_act),
        .raw_top     (raw_top)
    );

    // Complementary raw drives, one per channel
    always_comb begin
        raw_pair         = '0;
        raw_pair[CH_TOP] = raw_top;
        raw_pair[CH_BOT] = !raw_top;
    end

    // One deadtime generator per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dead
        dtc_dead_gen #(
            .DT_W (DT_W)
        ) u_dead (
            .clk         (clk),
            .rst_n       (rst_n),
            .raw_in      (raw_pair[ch]),
            .dead_cycles (dead_cycles),
            .gate_out    (gate[ch]),
            .turn_on     (turn_on[ch])
        );
    end

    // Sense capture at each turn-on
    dtc_mark_cap #(
        .NCH (NUM_CH)
    ) u_mark (
        .clk      (clk),
        .rst_n    (rst_n),
        .sense_in (isense),
        .cap_evt  (turn_on),
        .mark     (dt_mark)
    );

    assign pwm_top = gate[CH_TOP];
    assign pwm_bot = gate[CH_BOT];

endmodule

// File: rtl/dtc_pwm_pair_chk.sv
// Module: assertion checker for dtc_pwm_pair, bound to every instance.
// Observes the ports plus the period count and the active duty.
module dtc_pwm_pair_chk #(
    parameter int CNT_W  = 4,
    parameter int DUTY_W = 8,
    parameter int DT_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_top,
    input logic              pwm_bot,
    input logic [1:0]        dt_mark,
    input logic [DT_W-1:0]   dead_cycles,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [DUTY_W-1:0] duty_act
);

    // R1: reset clears outputs and markers
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!pwm_top && !pwm_bot && dt_mark == 2'b00));

    // R6: outputs never on together
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_top && pwm_bot));

    // R6: low-to-high handover leaves a gap when deadtime is nonzero
    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_bot) && dead_cycles != '0) |-> !pwm_top);

    // R3: active duty changes only at a period start
    p_src_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(duty_act));

    // R10: markers hold unless an output has just turned on
    p_mark_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(pwm_top) && !$rose(pwm_bot)) |-> $stable(dt_mark));

endmodule

bind dtc_pwm_pair dtc_pwm_pair_chk #(
    .CNT_W  (CNT_W),
    .DUTY_W (DUTY_W),
    .DT_W   (DT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_top     (pwm_top),
    .pwm_bot     (pwm_bot),
    .dt_mark     (dt_mark),
    .dead_cycles (dead_cycles),
    .cnt_q       (cnt_q),
    .duty_act    (duty_act)
);

// File: tb/test_dtc_pwm_pair.sv
// Bench: drives a small configuration of dtc_pwm_pair and checks both
// outputs and both markers on every cycle against an arithmetic model.
module test_dtc_pwm_pair;

    localparam int P      = 8;
    localparam int DUTY_W = 4;
    localparam int DT_W   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DUTY_W-1:0] duty_even = '0;
    logic [DUTY_W-1:0] duty_odd = '0;
    logic              src_sel = 1'b0;
    logic [DT_W-1:0]   dead_cycles = '0;
    logic              isense = 1'b0;
    logic              pwm_top;
    logic              pwm_bot;
    logic [1:0]        dt_mark;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // model state
    int   cnt_m = 0;
    int   duty_m = 0;
    int   run_t = 0;
    int   run_b = 0;
    bit   s1_m = 0;
    bit   s2_m = 0;
    bit   e_top = 0;
    bit   e_bot = 0;
    bit [1:0] e_mark = 2'b00;
    string tag_top = "R4";
    string tag_bot = "R5";

    always #10 clk = ~clk;  // 50 MHz

    dtc_pwm_pair #(
        .PERIOD (P),
        .DUTY_W (DUTY_W),
        .DT_W   (DT_W)
    ) i_dtc_pwm_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .duty_even   (duty_even),
        .duty_odd    (duty_odd),
        .src_sel     (src_sel),
        .dead_cycles (dead_cycles),
        .isense      (isense),
        .pwm_top     (pwm_top),
        .pwm_bot     (pwm_bot),
        .dt_mark     (dt_mark)
    );

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Advance model and design by one edge, then compare at the negedge
    task automatic tick();
        bit raw;
        bit nt;
        bit nb;
        if (!rst_n) begin
            cnt_m = 0; duty_m = 0; run_t = 0; run_b = 0;
            s1_m = 0; s2_m = 0; e_top = 0; e_bot = 0; e_mark = 2'b00;
        end else begin
            raw = (cnt_m < duty_m);
            run_t = raw ? ((run_t < 1000) ? run_t + 1 : run_t) : 0;
            run_b = !raw ? ((run_b < 1000) ? run_b + 1 : run_b) : 0;
            nt = (run_t >= int'(dead_cycles) + 1);
            nb = (run_b >= int'(dead_cycles) + 1);
            if (nt && !e_top) e_mark[0] = s2_m;
            if (nb && !e_bot) e_mark[1] = s2_m;
            s2_m = s1_m;
            s1_m = isense;
            e_top = nt;
            e_bot = nb;
            if (cnt_m == P - 1) begin
                cnt_m = 0;
                duty_m = src_sel ? int'(duty_odd) : int'(duty_even);
            end else begin
                cnt_m++;
            end
        end
        @(negedge clk);
        cyc++;
        chk(int'(pwm_top), int'(e_top), tag_top, "pwm_top");
        chk(int'(pwm_bot), int'(e_bot), tag_bot, "pwm_bot");
        chk(int'(pwm_top & pwm_bot), 0, "R6", "overlap");
        chk(int'(dt_mark), int'(e_mark), "R9 R10", "dt_mark");
        isense = cyc[2] ^ cyc[5];
    endtask

    task automatic do_reset(input int dt);
        rst_n = 1'b0;
        dead_cycles = DT_W'(dt);
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic count_p(output int ct, output int cb);
        ct = 0; cb = 0;
        for (int i = 0; i < P; i++) begin
            tick();
            ct += int'(pwm_top);
            cb += int'(pwm_bot);
        end
    endtask

    task automatic to_period_start();
        while (cnt_m != 0) tick();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ct;
        int cb;
        int hi;

        // R1: reset state
        @(negedge clk);
        do_reset(0);
        chk(int'(pwm_top), 0, "R1", "pwm_top after reset");
        chk(int'(pwm_bot), 0, "R1", "pwm_bot after reset");
        chk(int'(dt_mark), 0, "R1", "dt_mark after reset");

        // R2: odd then even source, deadtime 0
        tag_top = "R2";
        duty_even = 4'd2; duty_odd = 4'd6; src_sel = 1'b1;
        repeat (3 * P) tick();
        to_period_start();
        count_p(ct, cb);
        chk(ct, 6, "R2", "top high count with odd source");
        src_sel = 1'b0;
        repeat (2 * P) tick();
        to_period_start();
        count_p(ct, cb);
        chk(ct, 2, "R2", "top high count with even source");

        // R3: mid-period select change waits for period end
        tag_top = "R3";
        while (cnt_m != 4) tick();
        src_sel = 1'b1;
        hi = 0;
        do begin
            tick();
            hi += int'(pwm_top);
        end while (cnt_m != 0);
        chk(hi, 0, "R3", "top highs after mid-period select change");
        count_p(ct, cb);
        chk(ct, 6, "R3", "top high count in following period");

        // R7: short pulse suppressed, longer one shortened
        tag_top = "R7";
        src_sel = 1'b0; duty_even = 4'd3;
        do_reset(3);
        repeat (3 * P) tick();
        to_period_start();
        count_p(ct, cb);
        chk(ct, 0, "R7", "pulse of deadtime length suppressed");
        chk(cb, P - 3 - 3, "R7", "bottom pulse shortened");
        duty_even = 4'd5;
        repeat (2 * P) tick();
        to_period_start();
        count_p(ct, cb);
        chk(ct, 2, "R7", "pulse shortened by deadtime");

        // R8: duty extremes
        tag_top = "R8";
        duty_even = 4'd0;
        do_reset(2);
        repeat (3 * P) tick();
        count_p(ct, cb);
        chk(ct, 0, "R8", "top count at duty 0");
        chk(cb, P, "R8", "bottom count at duty 0");
        duty_even = 4'd8;
        repeat (3 * P) tick();
        count_p(ct, cb);
        chk(ct, P, "R8", "top count at duty PERIOD");
        chk(cb, 0, "R8", "bottom count at duty PERIOD");
        duty_even = 4'd13;
        repeat (3 * P) tick();
        count_p(ct, cb);
        chk(ct, P, "R8", "top count above PERIOD");

        // Sweep over deadtimes and duty pairs with mid-period selects
        tag_top = "R4";
        for (int dt = 0; dt < 5; dt++) begin
            do_reset(dt);
            for (int de = 0; de < 11; de++) begin
                duty_even = DUTY_W'(de);
                duty_odd  = DUTY_W'((de * 3 + 1) % 11);
                for (int i = 0; i < 3 * P; i++) begin
                    if (i == de % P + 1) src_sel = ~src_sel;
                    if (i == 2 * P - 3) duty_odd = DUTY_W'((de + 5) % 11);
                    tick();
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule